// File: doc/BRIEF.md
# Credit-Counted Increment Pipeline Wrapper

This block puts valid/ready stream interfaces around a fixed-latency arithmetic pipeline that has no way to stall. Each incoming 32-bit word is incremented by one while it moves through a chain of registers. The result then drops into a first-word-fall-through output buffer. The downstream side reads the head of that buffer directly.

Backpressure never reaches the pipeline registers. A single occupancy counter tracks every word the block has accepted but not yet delivered, whether the word is still moving through the pipeline or already buffered. Upstream ready is derived from that counter alone. Because of this, the buffer takes every word leaving the pipeline without checking whether it is full, and a word can never be dropped. The pipeline latency is a parameter and must be between 1 and the buffer depth, which is checked at elaboration.

Top module: `credit_pipe_wrapper`

## Requirements
- R1: Every delivered word equals its accepted input plus one, modulo 2^32 (input 0xFFFFFFFF yields 0x00000000).
- R2: Accepted words are delivered in acceptance order, each exactly once, with none lost or added.
- R3: A word accepted into an empty block is presented on `dnValid`/`dnData` after exactly PIPE_LAT+1 rising edges, counting the edge that accepted it.
- R4: `upReady` is high exactly when the count of accepted-but-undelivered words is below FIFO_DEPTH. With `dnReady` held low, exactly FIFO_DEPTH words are accepted and `upReady` then stays low.
- R5: A word offered while `upReady` is low is discarded: it never appears at the output and does not change the count.
- R6: The output buffer never overflows. After FIFO_DEPTH words are stored with `dnReady` low, all FIFO_DEPTH of them are later delivered.
- R7: While `dnValid` is high and `dnReady` is low, `dnValid` stays high and `dnData` holds its value.
- R8: A cycle with both an upstream and a downstream handshake leaves the count unchanged.
- R9: A synchronous active-high reset empties the block: after reset `upReady` is 1 and `dnValid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| upData | input | DATA_W | Incoming word |
| upValid | input | 1 | Incoming word is valid |
| upReady | output | 1 | Block can accept a word this cycle |
| dnData | output | DATA_W | Head word of the output buffer |
| dnValid | output | 1 | Output buffer holds a word |
| dnReady | input | 1 | Consumer takes the head word this cycle |

## Verification
**Counter too high.** If the occupancy counter drifts above the true number of words in the block, `upReady` falls early. The block then runs dry and never refills, and this shows at the ports as soon as the fill-to-depth test counts fewer than FIFO_DEPTH acceptances.

**Counter too low.** If the counter drifts low, the buffer is overrun. The scoreboard then sees an overwritten or duplicated word once the buffer drains, within one buffer depth of reads.

**Broken pipeline valid.** A broken valid bit in the pipeline shows up as a missing or spurious word, detected at the next read.

**Wrong latency.** A wrong stage count moves the first `dnValid` away from edge PIPE_LAT+1.

// File: rtl/cpw_pkg.sv
package cpw_pkg;
  typedef struct packed {
    logic admit;  // upstream handshake this cycle
    logic pop;    // downstream handshake this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/creditCtrl.sv
module creditCtrl
  import cpw_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        upValid,
  input  logic        dnValid,
  input  logic        dnReady,
  output logic        upReady,
  output ctrlStrobe_t strb,
  output logic [CW-1:0] credits
);
  logic [CW-1:0] count;

  always_comb begin
    upReady    = (count < CW'(DEPTH));
    strb.admit = upValid & upReady;
    strb.pop   = dnValid & dnReady;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else begin
      case ({strb.admit, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign credits = count;

  // R8: simultaneous handshakes keep the count
  a_r8_both_hold: assert property (@(posedge clk) disable iff (rst)
    (strb.admit && strb.pop) |=> $stable(count))
    else $error("count moved on a cycle with both handshakes");

  // R5: a rejected offer does not move the count
  a_r5_reject_hold: assert property (@(posedge clk) disable iff (rst)
    (upValid && !upReady && !strb.pop) |=> $stable(count))
    else $error("rejected word changed the count");

  // R4: count never exceeds the buffer depth
  a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH))
    else $error("count above depth");
endmodule

// File: rtl/incPipe.sv
module incPipe #(
  parameter int W   = 32,
  parameter int LAT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [W-1:0] inData,
  output logic         outValid,
  output logic [W-1:0] outData
);
  generate
    for (genvar s = 0; s < LAT; s++) begin : g_stage
      logic         v;
      logic [W-1:0] d;
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) v <= 1'b0;
          else     v <= inValid;
          d <= inData + W'(1);
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) v <= 1'b0;
          else     v <= g_stage[s-1].v;
          d <= g_stage[s-1].d;
        end
      end
    end
  endgenerate

  assign outValid = g_stage[LAT-1].v;
  assign outData  = g_stage[LAT-1].d;
endmodule

// File: rtl/fwftFifo.sv
module fwftFifo #(
  parameter int W     = 32,
  parameter int DEPTH = 128,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrEn,
  input  logic [W-1:0]  wrData,
  input  logic          rdEn,
  output logic          headValid,
  output logic [W-1:0]  headData,
  output logic [CW-1:0] fill
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (wrEn) wrPtr <= nextPtr(wrPtr);
      if (rdEn) rdPtr <= nextPtr(rdPtr);
      case ({wrEn, rdEn})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  assign headValid = (fill != '0);
  assign headData  = mem[rdPtr];

  // R6: a write never lands on a full buffer
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wrEn |-> (fill < CW'(DEPTH) || rdEn))
    else $error("write into full buffer");

  // R7: unread head stays put
  a_r7_head_hold: assert property (@(posedge clk) disable iff (rst)
    (headValid && !rdEn) |=> (headValid && $stable(headData)))
    else $error("head changed without a read");
endmodule

// File: rtl/incDatapath.sv
module incDatapath
  import cpw_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 128,
  parameter int LAT   = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  ctrlStrobe_t   strb,
  input  logic [W-1:0]  inData,
  output logic          headValid,
  output logic [W-1:0]  headData,
  output logic [CW-1:0] fill
);
  logic         pipeValid;
  logic [W-1:0] pipeData;

  incPipe #(.W(W), .LAT(LAT)) uPipe (
    .clk(clk), .rst(rst),
    .inValid(strb.admit), .inData(inData),
    .outValid(pipeValid), .outData(pipeData)
  );

  fwftFifo #(.W(W), .DEPTH(DEPTH)) uFifo (
    .clk(clk), .rst(rst),
    .wrEn(pipeValid), .wrData(pipeData),
    .rdEn(strb.pop),
    .headValid(headValid), .headData(headData), .fill(fill)
  );
endmodule

// File: rtl/credit_pipe_wrapper.sv
module credit_pipe_wrapper
  import cpw_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 128,
  parameter int PIPE_LAT   = 4,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] upData,
  input  logic              upValid,
  output logic              upReady,
  output logic [DATA_W-1:0] dnData,
  output logic              dnValid,
  input  logic              dnReady
);
  generate
    if (PIPE_LAT < 1 || PIPE_LAT > FIFO_DEPTH) begin : g_badLat
      $error("PIPE_LAT must lie in 1..FIFO_DEPTH");
    end
  endgenerate

  ctrlStrobe_t   strb;
  logic [CW-1:0] credits;
  logic [CW-1:0] fill;

  creditCtrl #(.DEPTH(FIFO_DEPTH)) uCtrl (
    .clk(clk), .rst(rst),
    .upValid(upValid), .dnValid(dnValid), .dnReady(dnReady),
    .upReady(upReady), .strb(strb), .credits(credits)
  );

  incDatapath #(.W(DATA_W), .DEPTH(FIFO_DEPTH), .LAT(PIPE_LAT)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .inData(upData),
    .headValid(dnValid), .headData(dnData), .fill(fill)
  );

  // R6: buffered words never outnumber counted words
  a_r6_fill_in_credit: assert property (@(posedge clk) disable iff (rst)
    fill <= credits)
    else $error("buffer holds more than counted");

  // R4: admission implies room for the buffer to take it
  a_r4_ready_room: assert property (@(posedge clk) disable iff (rst)
    upReady |-> (fill < CW'(FIFO_DEPTH)))
    else $error("ready while buffer full");
endmodule

// File: tb/sim_credit_pipe_wrapper.sv
module sim_credit_pipe_wrapper;
  localparam int W = 32;
  localparam int D = 128;
  localparam int L = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] upData = '0;
  logic         upValid = 1'b0;
  logic         upReady;
  logic [W-1:0] dnData;
  logic         dnValid;
  logic         dnReady = 1'b0;

  int checks = 0;
  int errors = 0;
  int popped = 0;
  bit lastAcc = 0;
  bit done = 0;
  logic [W-1:0] expQ[$];

  always #2 clk = ~clk;

  credit_pipe_wrapper #(.DATA_W(W), .FIFO_DEPTH(D), .PIPE_LAT(L)) u0 (
    .clk(clk), .rst(rst), .upData(upData), .upValid(upValid),
    .upReady(upReady), .dnData(dnData), .dnValid(dnValid), .dnReady(dnReady)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: sets inputs after a falling edge, records accepted words
  task automatic drive(input bit v, input logic [W-1:0] d, input bit r);
    @(negedge clk);
    upValid = v;
    upData  = d;
    dnReady = r;
    #1;
    lastAcc = upValid && upReady;
    if (lastAcc) expQ.push_back(upData + 32'd1);
  endtask

  // monitor: compares every delivered word against the queue (R1, R2)
  always @(negedge clk) begin
    #1;
    if (!rst && dnValid && dnReady) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2 word with nothing expected", dnData, '0);
      end else begin
        logic [W-1:0] e;
        e = expQ.pop_front();
        chk(dnData == e, "R1 R2 delivered word", dnData, e);
      end
      popped++;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int k;
    int acc;
    int p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(upReady == 1'b1, "R9 ready after reset", upReady, 1);
    chk(dnValid == 1'b0, "R9 empty after reset", dnValid, 0);

    // R3 latency and R1 wrap
    drive(1, 32'hFFFF_FFFF, 0);
    chk(lastAcc, "R4 accept when empty", lastAcc, 1);
    k = 0;
    do begin
      drive(0, '0, 0);
      k++;
    end while (!dnValid && k < 50);
    chk(k == L + 1, "R3 first output edge", k, L + 1);
    chk(dnData == 32'h0, "R1 wrap to zero", dnData, 0);
    // R7 hold while not read
    for (int i = 0; i < 3; i++) begin
      drive(0, '0, 0);
      chk(dnValid && dnData == 32'h0, "R7 head held", dnData, 0);
    end
    drive(0, '0, 1);
    drive(0, '0, 0);
    chk(!dnValid, "R2 single word delivered once", dnValid, 0);

    // R4/R5/R6 fill to depth
    acc = 0;
    for (int i = 0; i < D + 8; i++) begin
      drive(1, 32'h1000 + i, 0);
      if (lastAcc) acc++;
    end
    chk(acc == D, "R4 accepted count at full", acc, D);
    chk(!upReady, "R4 ready low when full", upReady, 0);
    for (int i = 0; i < L + 3; i++) begin
      drive(1, 32'hDEAD_0000 + i, 0);
      chk(!upReady && !lastAcc, "R5 offer rejected while full", upReady, 0);
    end
    p0 = popped;
    repeat (D + L + 5) drive(0, '0, 1);
    drive(0, '0, 0);
    chk(popped - p0 == D, "R6 all stored words delivered", popped - p0, D);
    chk(expQ.size() == 0, "R5 no rejected word delivered", expQ.size(), 0);
    chk(upReady, "R4 ready after drain", upReady, 1);

    // R8 simultaneous handshakes at depth-1
    for (int i = 0; i < D - 1; i++) drive(1, 32'h2000 + i, 0);
    repeat (L + 2) drive(0, '0, 0);
    chk(dnValid, "R8 setup head present", dnValid, 1);
    drive(1, 32'h3000, 1);
    chk(lastAcc, "R8 accept with pop", lastAcc, 1);
    drive(0, '0, 0);
    chk(upReady, "R8 count unchanged by both", upReady, 1);
    drive(1, 32'h3001, 0);
    drive(0, '0, 0);
    chk(!upReady, "R8 R4 full after one more", upReady, 0);
    repeat (D + L + 5) drive(0, '0, 1);
    drive(0, '0, 0);
    chk(expQ.size() == 0, "R2 drained after R8 test", expQ.size(), 0);

    // random traffic, R1 R2 via monitor
    for (int i = 0; i < 4000; i++) begin
      if (i < 2000) drive($urandom_range(0, 1) == 1, $urandom, $urandom_range(0, 3) == 0);
      else          drive($urandom_range(0, 2) != 0, $urandom, $urandom_range(0, 1) == 1);
    end
    repeat (D + L + 10) drive(0, '0, 1);
    drive(0, '0, 0);
    chk(expQ.size() == 0, "R2 nothing lost after random", expQ.size(), 0);
    chk(!dnValid, "R2 nothing extra after random", dnValid, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule